// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small multicycle processor with eight general registers, a signed arithmetic unit and a single memory port. Memory is word addressed. One word holds either one field of an instruction or one data value. An instruction is one to four words long and starts with an opcode word, which is a decimal value. The core reads the opcode, works out from it how many operand words follow, reads those words one at a time, and then executes the instruction. Only load, store and print touch data memory. Arithmetic always reads and writes registers.

Every memory access is a single-port transaction. The core drives an address together with a read strobe or a write strobe. Read data comes back one cycle after the read strobe. Each fetch step puts the PC on the address lines, issues a read, and increments the PC. On the next cycle the returned word is captured into the instruction fields. A print instruction reads a memory word and presents it on `print_data` with a one-cycle `print_valid` strobe. A halt instruction, or an opcode the core does not recognise, stops the core until reset.

The controller has five states, each named below with its transitions:
- `S_FETCH` issues the read at the PC and always moves to `S_CAPTURE`.
- `S_CAPTURE` stores the returned word. It goes back to `S_FETCH` while operand words remain, to `S_EXEC` once the instruction is complete, and to `S_HALT` on an unknown opcode.
- `S_EXEC` goes to `S_HALT` for halt, to `S_MEMRD` for load and print, and to `S_FETCH` otherwise.
- `S_MEMRD` always returns to `S_FETCH`.
- `S_HALT` only leaves on reset.

Top module: `ldst_core`

## Requirements
- R1: While reset is low, `halted`, `illegal` and `print_valid` are 0 and the PC takes the value of `start_pc`. In the first cycle after reset the core reads address `start_pc`.
- R2: Opcode words and their lengths are as follows: 0 is halt (1 word); 10 div, 20 mul, 30 sub and 40 add (4 words); 50 load, 60 store and 71..76 conditional branches (3 words); 70 ba and 90 print (2 words). Every word takes one fetch cycle and one capture cycle, and execution takes one further cycle, plus one more for load and print. A halt at `start_pc` therefore raises `halted` after 3 cycles.
- R3: Arithmetic words are opcode, a, b, c. The instruction writes reg[c] = reg[a] op reg[b] in signed 32-bit two's complement, and the product keeps its low 32 bits.
- R4: Division truncates toward zero. A zero divisor writes 0 to the destination.
- R5: Load words are opcode, addr, r and set reg[r] = mem[addr]. Store words are opcode, r, addr and set mem[addr] = reg[r].
- R6: Conditional branch words are opcode, r, addr. The branch jumps to addr when reg[r] is <0 (71), <=0 (72), ==0 (73), !=0 (74), >=0 (75) or >0 (76) compared with zero, and otherwise continues after the instruction. Words for ba (70) are opcode, addr, and it always jumps.
- R7: Print (words opcode, addr) pulses `print_valid` for exactly one cycle with `print_data` equal to mem[addr].
- R8: Once `halted` is 1 it stays 1 until reset, and the core makes no further memory reads or writes.
- R9: An opcode word outside the list in R2 sets `illegal` and `halted`, and the instruction is not executed.
- R10: A memory read strobe and a memory write strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pc | input | ADDR_W | Address of the first instruction, taken during reset |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Data to be written |
| mem_rdata | input | 32 | Data read back, one cycle after `mem_rd` |
| print_valid | output | 1 | One-cycle strobe of a print instruction |
| print_data | output | 32 | Value printed |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unknown opcode |

## Verification
The four arithmetic operations are swept over every ordered pair from a set of eight signed values. The set includes zero, ±1, and pairs of mixed sign. These runs separate an a/b operand swap from the correct order, truncation toward zero from flooring, and the zero-divisor rule from a raw divide. Each of the six sign-test branches is tried with negative, zero and positive register values. This shows whether each condition treats zero correctly and whether a taken branch lands on its target and an untaken one falls through. Cycle counts from reset to halt on a mixed-length program, a multi-step signed expression, and an unknown opcode check the per-opcode word counts and the stopping rules.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t OPC_HALT  = 32'd0;
    localparam word_t OPC_DIV   = 32'd10;
    localparam word_t OPC_MUL   = 32'd20;
    localparam word_t OPC_SUB   = 32'd30;
    localparam word_t OPC_ADD   = 32'd40;
    localparam word_t OPC_LOAD  = 32'd50;
    localparam word_t OPC_STORE = 32'd60;
    localparam word_t OPC_BA    = 32'd70;
    localparam word_t OPC_BLT   = 32'd71;
    localparam word_t OPC_BLE   = 32'd72;
    localparam word_t OPC_BEQ   = 32'd73;
    localparam word_t OPC_BNE   = 32'd74;
    localparam word_t OPC_BGE   = 32'd75;
    localparam word_t OPC_BGT   = 32'd76;
    localparam word_t OPC_PRINT = 32'd90;

    typedef enum logic [2:0] {
        S_FETCH,
        S_CAPTURE,
        S_EXEC,
        S_MEMRD,
        S_HALT
    } core_state_t;

    // Words in the instruction, opcode included; 0 marks an unknown opcode.
    function automatic int op_words(input word_t w);
        case (w)
            OPC_HALT:                                  op_words = 1;
            OPC_DIV, OPC_MUL, OPC_SUB, OPC_ADD:        op_words = 4;
            OPC_LOAD, OPC_STORE,
            OPC_BLT, OPC_BLE, OPC_BEQ,
            OPC_BNE, OPC_BGE, OPC_BGT:                 op_words = 3;
            OPC_BA, OPC_PRINT:                         op_words = 2;
            default:                                   op_words = 0;
        endcase
    endfunction

    function automatic logic is_arith(input word_t w);
        return (w == OPC_DIV) || (w == OPC_MUL) || (w == OPC_SUB) || (w == OPC_ADD);
    endfunction

endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile
    import ldst_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  word_t            wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output word_t            rdata_a,
    output word_t            rdata_b
);

    word_t regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/ldst_alu.sv
module ldst_alu
    import ldst_pkg::*;
(
    input  word_t opc,
    input  word_t a,
    input  word_t b,
    output word_t y
);

    logic signed [WORD_W-1:0] sa, sb;
    assign sa = signed'(a);
    assign sb = signed'(b);

    always_comb begin
        y = '0;
        if (opc == OPC_ADD) begin
            y = word_t'(sa + sb);
        end else if (opc == OPC_SUB) begin
            y = word_t'(sa - sb);
        end else if (opc == OPC_MUL) begin
            y = word_t'(sa * sb);
        end else if (opc == OPC_DIV) begin
            if (sb == '0) begin
                y = '0;
            end else if (sb == -1) begin
                y = word_t'(-sa);
            end else begin
                y = word_t'(sa / sb);
            end
        end
    end

endmodule

// File: rtl/ldst_cond.sv
module ldst_cond
    import ldst_pkg::*;
(
    input  word_t opc,
    input  word_t val,
    output logic  taken
);

    logic neg, zero;
    assign neg  = val[WORD_W-1];
    assign zero = (val == '0);

    always_comb begin
        case (opc)
            OPC_BA:  taken = 1'b1;
            OPC_BLT: taken = neg;
            OPC_BLE: taken = neg | zero;
            OPC_BEQ: taken = zero;
            OPC_BNE: taken = !zero;
            OPC_BGE: taken = !neg;
            OPC_BGT: taken = !neg && !zero;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldst_core.sv
module ldst_core
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_pc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              print_valid,
    output logic [31:0]       print_data,
    output logic              halted,
    output logic              illegal
);

    core_state_t       state;
    logic [ADDR_W-1:0] pc;
    logic [1:0]        idx;
    word_t             opw;
    logic [ADDR_W-1:0] fld1, fld2;
    logic [IDX_W-1:0]  fld3;
    logic              illegal_q;

    word_t             rd_a, rd_b, alu_y;
    logic              br_taken;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    word_t             rf_wdata;
    int                cur_len;

    ldst_regfile #(.NREG(NREG)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fld1[IDX_W-1:0]),
        .raddr_b (fld2[IDX_W-1:0]),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    ldst_alu i_alu (
        .opc (opw),
        .a   (rd_a),
        .b   (rd_b),
        .y   (alu_y)
    );

    ldst_cond i_cond (
        .opc   (opw),
        .val   (rd_a),
        .taken (br_taken)
    );

    assign cur_len = (idx == 2'd0) ? op_words(mem_rdata) : op_words(opw);

    // State register and instruction fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_FETCH;
            pc        <= start_pc;
            idx       <= '0;
            opw       <= '0;
            fld1      <= '0;
            fld2      <= '0;
            fld3      <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state)
                S_FETCH: begin
                    pc    <= pc + 1'b1;
                    state <= S_CAPTURE;
                end
                S_CAPTURE: begin
                    case (idx)
                        2'd0:    opw  <= mem_rdata;
                        2'd1:    fld1 <= mem_rdata[ADDR_W-1:0];
                        2'd2:    fld2 <= mem_rdata[ADDR_W-1:0];
                        default: fld3 <= mem_rdata[IDX_W-1:0];
                    endcase
                    if (cur_len == 0) begin
                        illegal_q <= 1'b1;
                        state     <= S_HALT;
                    end else if (int'(idx) + 1 == cur_len) begin
                        idx   <= '0;
                        state <= S_EXEC;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_EXEC: begin
                    if (opw == OPC_HALT) begin
                        state <= S_HALT;
                    end else if (opw == OPC_LOAD || opw == OPC_PRINT) begin
                        state <= S_MEMRD;
                    end else begin
                        if (br_taken) begin
                            pc <= (opw == OPC_BA) ? fld1 : fld2;
                        end
                        state <= S_FETCH;
                    end
                end
                S_MEMRD: state <= S_FETCH;
                S_HALT:  state <= S_HALT;
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        mem_addr    = pc;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_wdata   = '0;
        rf_we       = 1'b0;
        rf_waddr    = fld3;
        rf_wdata    = alu_y;
        print_valid = 1'b0;
        print_data  = '0;
        unique case (state)
            S_FETCH: begin
                mem_addr = pc;
                mem_rd   = 1'b1;
            end
            S_CAPTURE: ;
            S_EXEC: begin
                if (opw == OPC_LOAD || opw == OPC_PRINT) begin
                    mem_addr = fld1;
                    mem_rd   = 1'b1;
                end else if (opw == OPC_STORE) begin
                    mem_addr  = fld2;
                    mem_wr    = 1'b1;
                    mem_wdata = rd_a;
                end else if (is_arith(opw)) begin
                    rf_we = 1'b1;
                end
            end
            S_MEMRD: begin
                if (opw == OPC_LOAD) begin
                    rf_we    = 1'b1;
                    rf_waddr = fld2[IDX_W-1:0];
                    rf_wdata = mem_rdata;
                end else begin
                    print_valid = 1'b1;
                    print_data  = mem_rdata;
                end
            end
            S_HALT: ;
        endcase
    end

    assign halted  = (state == S_HALT);
    assign illegal = illegal_q;

    // R2: each fetch step advances the PC by one word
    a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (pc == $past(pc) + 1'b1));

    // R7: print strobe lasts one cycle
    a_r7_print_single: assert property (@(posedge clk) disable iff (!rst_n)
        print_valid |=> !print_valid);

    // R8: halted is sticky
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: no memory traffic after halting
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R9: an unknown opcode always leaves the core halted
    a_r9_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R10: one memory operation per cycle
    a_r10_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/test_ldst_core.sv
`timescale 1ns/1ps
module test_ldst_core;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] start_pc = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          print_valid;
    logic [31:0]   print_data;
    logic          halted, illegal;

    always #2.5 clk = ~clk;

    ldst_core #(.ADDR_W(AW), .NREG(8)) i_ldst_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pc    (start_pc),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .print_valid (print_valid),
        .print_data  (print_data),
        .halted      (halted),
        .illegal     (illegal)
    );

    // Bench RAM with a loading port used while the core is in reset
    logic [31:0]   ram [256];
    logic          ld_clr = 1'b0;
    logic          ld_we  = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;

    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) ram[i] <= '0;
        end else if (ld_we) begin
            ram[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            ram[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    // Print monitor and port-overlap monitor
    int  prints [16];
    int  np;
    bit  overlap = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            np <= 0;
        end else begin
            if (print_valid && np < 16) begin
                prints[np] <= $signed(print_data);
                np <= np + 1;
            end
            if (mem_rd && mem_wr) overlap <= 1'b1;
        end
    end

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input int v);
        ld_we = 1'b1; ld_addr = AW'(a); ld_data = v;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic clear_mem();
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
    endtask

    task automatic put_prog(input int base, input int p[]);
        foreach (p[i]) put(base + i, p[i]);
    endtask

    task automatic run(input int start, output int cyc);
        rst_n = 1'b0;
        start_pc = AW'(start);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic int arith_exp(input int op, input int a, input int b);
        case (op)
            40: return a + b;
            30: return a - b;
            20: return a * b;
            default: return (b == 0) ? 0 : a / b;
        endcase
    endfunction

    function automatic bit cond_exp(input int op, input int v);
        case (op)
            71: return v < 0;
            72: return v <= 0;
            73: return v == 0;
            74: return v != 0;
            75: return v >= 0;
            default: return v > 0;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int cyc;
        int vals[8] = '{-7, -3, -1, 0, 1, 2, 5, 9};
        int ops[4]  = '{40, 30, 20, 10};
        int bvals[5] = '{-5, -1, 0, 1, 7};

        // R1: reset state and first fetch address
        clear_mem();
        start_pc = AW'(37);
        repeat (2) @(negedge clk);
        chk(!halted && !illegal && !print_valid, "R1 reset outputs", {halted, illegal, print_valid}, 0);
        rst_n = 1'b1;
        #1;
        chk(mem_rd && mem_addr == AW'(37), "R1 first fetch address", int'(mem_addr), 37);

        // R2 and R8: halt at start_pc, cycle count and sticky quiet halt
        clear_mem();
        run(37, cyc);
        chk(cyc == 3, "R2 halt-only cycles", cyc, 3);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(halted && !mem_rd && !mem_wr && !illegal, "R8 halted stays quiet",
                {halted, mem_rd, mem_wr}, 4);
        end

        // R2: mixed-length program timing from a nonzero start
        clear_mem();
        put_prog(20, '{40, 1, 2, 3, 50, 60, 1, 90, 60, 0});
        put(60, 77);
        run(20, cyc);
        chk(cyc == 26, "R2 mixed program cycles", cyc, 26);
        chk(np == 1 && prints[0] == 77, "R7 print after load", prints[0], 77);

        // R3 R4 R5 R7: arithmetic sweep over ordered operand pairs
        foreach (ops[oi]) begin
            foreach (vals[ai]) begin
                foreach (vals[bi]) begin
                    int e;
                    clear_mem();
                    put_prog(0, '{50, 40, 1, 50, 41, 2, ops[oi], 1, 2, 3,
                                  60, 3, 42, 90, 42, 0});
                    put(40, vals[ai]);
                    put(41, vals[bi]);
                    run(0, cyc);
                    e = arith_exp(ops[oi], vals[ai], vals[bi]);
                    chk(np == 1, "R7 one print pulse", np, 1);
                    if (ops[oi] == 10)
                        chk(prints[0] == e, "R4 signed divide", prints[0], e);
                    else
                        chk(prints[0] == e, "R3 arithmetic result", prints[0], e);
                    chk($signed(ram[42]) == e, "R5 stored word", $signed(ram[42]), e);
                end
            end
        end

        // R6: sign-test branches over negative, zero and positive values
        for (int op = 71; op <= 76; op++) begin
            foreach (bvals[vi]) begin
                int e;
                clear_mem();
                put_prog(0, '{50, 40, 3, op, 3, 9, 90, 41, 0, 90, 42, 0});
                put(40, bvals[vi]);
                put(41, 111);
                put(42, 222);
                run(0, cyc);
                e = cond_exp(op, bvals[vi]) ? 222 : 111;
                chk(np == 1 && prints[0] == e, "R6 conditional branch", prints[0], e);
            end
        end

        // R6: unconditional branch
        clear_mem();
        put_prog(0, '{70, 9, 90, 41, 0});
        put_prog(9, '{90, 42, 0});
        put(41, 111);
        put(42, 222);
        run(0, cyc);
        chk(np == 1 && prints[0] == 222, "R6 ba jumps", prints[0], 222);

        // R3 R4: multi-step signed expression (12-2)*(12-9)/(12-14) = -15
        clear_mem();
        put_prog(100, '{50, 200, 1, 50, 201, 2, 50, 202, 3, 50, 203, 4,
                        30, 1, 2, 0, 30, 1, 3, 5, 20, 0, 5, 0,
                        30, 1, 4, 5, 10, 0, 5, 0, 60, 0, 204, 90, 204, 0});
        put(200, 12); put(201, 2); put(202, 9); put(203, 14);
        run(100, cyc);
        chk(np == 1 && prints[0] == -15, "R4 expression result", prints[0], -15);
        chk(!illegal, "R9 no illegal on valid code", illegal, 0);

        // R9: unknown opcode stops the core without executing
        clear_mem();
        put_prog(0, '{55, 90, 5, 0});
        put(5, 9);
        run(0, cyc);
        chk(illegal && halted, "R9 illegal flag", {illegal, halted}, 3);
        chk(np == 0, "R9 no execution", np, 0);
        repeat (5) @(negedge clk);
        chk(halted && illegal, "R9 R8 remains stopped", {illegal, halted}, 3);

        // R10: port exclusivity across all runs
        chk(!overlap, "R10 read/write exclusive", overlap, 0);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule